// File: doc/BRIEF.md
# Linked-Descriptor XOR and Pattern Fill Engine

This block is a memory-to-memory accelerator. Software places a linked list of descriptors in memory. It writes the address of the first descriptor into a register and then sets a run bit. The engine then reads each descriptor in turn and processes its destination region one 32-bit word at a time. For each word offset it does one of two things. It may read up to eight source regions at that offset, loading the first into an internal accumulator and XORing each later source into it, so that a single source gives a plain copy. Or it may replicate a 32-bit value held in the descriptor. The result is written to the destination, and the offset advances by four bytes until the byte count is used up.

When the final descriptor finishes, the engine returns to idle and posts completion flags in a status register. If the final descriptor asked for it, the engine also raises an interrupt. An error response from memory stops the walk and sets an abort flag. Writing zero to the control register stops the engine at once. Status flags are cleared by writing ones to them.

Top module: `xfe_top`

## Requirements
- R1: While reset is held and in the cycle after it, the status register reads 0, `irq` is low and `mem_req` is low.
- R2: A register write to address 1 with bit 0 set, made while the engine is idle, starts a chain walk at the address held in register 0 (written at address 0). The low 5 bits of that address are ignored, because descriptors sit on 32-byte boundaries.
- R3: A descriptor whose only used slot is slot 1 with command code 1 (load) copies the source region word for word to the destination.
- R4: Control word encoding: slot k (k = 1..8) has a 3-bit command at bits [3k-1:3k-3], where 0 = unused, 1 = load accumulator, 2 = XOR into accumulator and 3 = fill (slot 1 only). Bit 24 = extended source group enable, bit 25 = destination write enable and bit 26 = interrupt enable. Each destination word is the XOR of the same-offset words of all slots coded 1 or 2.
- R5: Slots 5 to 8 take part only when bit 24 of the control word is set. With bit 24 clear, their command codes are ignored and their address words are not read.
- R6: With command 3 in slot 1, the slot-1 word itself (not memory at that address) is written to every destination word of the byte count. A zero word gives a zero fill.
- R7: With bit 25 of the control word clear, the descriptor makes no destination writes.
- R8: Descriptor layout, as byte offsets from its base: next pointer at 0, control at 4, byte count at 8, destination at 12, slot 1 to 4 sources at 16 to 28, slot 5 to 8 sources at 32 to 44. A non-zero next pointer chains to the descriptor it names, and zero ends the chain. Destination writes occur in descriptor order, then in ascending offset order. A memory request holds its address until it is acknowledged.
- R9: Status register at address 2 reads bit 0 = active, bit 1 = end-of-chain, bit 2 = end-of-transfer and bit 3 = master abort. When the chain ends, end-of-transfer is set. End-of-chain is set only if the final descriptor has bit 26 set, and `irq` follows end-of-chain.
- R10: Writing the status register clears each flag whose written bit is 1 and leaves the other flags unchanged. A flag that is set in the same cycle as a clearing write ends up set.
- R11: An error response to any memory request sets master abort and returns the engine to idle. No completion flag is set.
- R12: Writing the control register with bit 0 clear stops the engine. From the next cycle on, active is low and no memory request is made, and no completion flag is set.
- R13: The active bit is high from the start until the chain ends, an abort occurs or the engine is stopped. While it is low, `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 next pointer, 1 control, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledge or error |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Request failed with an error response |
| irq | output | 1 | End-of-chain interrupt |

## Verification
Two things can meet in one cycle: the engine setting a completion flag as the chain ends, and software writing ones to the status register to clear that same flag. The bench provokes this by starting a short chain and holding a clearing write to the end-of-chain bit on every cycle until the active bit drops. The clearing write is therefore present on exactly the edge where the flag is set. It then judges that end-of-chain reads back as set. Separately, every accepted destination write is compared as it happens against a queue of expected address and data pairs, which the bench computes from the descriptors.

// File: rtl/xfe_pkg.sv
package xfe_pkg;
    localparam int DATA_W     = 32;
    localparam int MAX_SRC    = 8;
    localparam int BASE_SLOTS = 4;
    localparam int DESC_HDR   = 4;
    localparam int DESC_WORDS = DESC_HDR + MAX_SRC;
    localparam int CMD_W      = 3;
    localparam int RA_W       = 2;
    localparam int ST_W       = 4;
    localparam int ALIGN_B    = 5;

    localparam int W_NEXT = 0;
    localparam int W_CTRL = 1;
    localparam int W_BC   = 2;
    localparam int W_DST  = 3;

    localparam int EXT_BIT = 24;
    localparam int DWE_BIT = 25;
    localparam int IE_BIT  = 26;

    localparam logic [CMD_W-1:0] CMD_NONE = 3'd0;
    localparam logic [CMD_W-1:0] CMD_LOAD = 3'd1;
    localparam logic [CMD_W-1:0] CMD_XOR  = 3'd2;
    localparam logic [CMD_W-1:0] CMD_FILL = 3'd3;

    localparam logic [RA_W-1:0] RA_NEXT = 2'd0;
    localparam logic [RA_W-1:0] RA_CTRL = 2'd1;
    localparam logic [RA_W-1:0] RA_STAT = 2'd2;

    localparam int ST_ACT = 0;
    localparam int ST_EOC = 1;
    localparam int ST_EOT = 2;
    localparam int ST_MA  = 3;

    typedef enum logic [1:0] {ACC_HOLD, ACC_LOAD, ACC_XOR} acc_op_e;

    typedef enum logic [2:0] {S_IDLE, S_FETCH, S_SLOT, S_READ, S_WRITE} seq_st_e;

    typedef struct packed {
        logic done;
        logic ie;
        logic abort;
    } evt_t;

    function automatic logic [DATA_W-1:0] align_desc(input logic [DATA_W-1:0] a);
        return {a[DATA_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
    endfunction
endpackage

// File: rtl/xfe_acc.sv
module xfe_acc
    import xfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_op_e           op,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else begin
            case (op)
                ACC_LOAD: acc <= din;
                ACC_XOR:  acc <= acc ^ din;
                default:  acc <= acc;
            endcase
        end
    end
endmodule

// File: rtl/xfe_regs.sv
module xfe_regs
    import xfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              busy,
    input  evt_t              evt,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] first_addr,
    output logic              start,
    output logic              stop,
    output logic [ST_W-1:0]   status,
    output logic              irq
);
    logic eoc_q, eot_q, ma_q;
    logic wr_stat;

    assign wr_stat = reg_wr && (reg_addr == RA_STAT);
    assign start   = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[0] && !busy;
    assign stop    = reg_wr && (reg_addr == RA_CTRL) && !reg_wdata[0];
    assign status  = {ma_q, eot_q, eoc_q, busy};
    assign irq     = eoc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_addr <= '0;
            eoc_q      <= 1'b0;
            eot_q      <= 1'b0;
            ma_q       <= 1'b0;
        end else begin
            if (reg_wr && (reg_addr == RA_NEXT))
                first_addr <= reg_wdata;
            // set wins over a same-cycle clearing write
            eoc_q <= (eoc_q & ~(wr_stat & reg_wdata[ST_EOC])) | (evt.done & evt.ie);
            eot_q <= (eot_q & ~(wr_stat & reg_wdata[ST_EOT])) | evt.done;
            ma_q  <= (ma_q  & ~(wr_stat & reg_wdata[ST_MA]))  | evt.abort;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_NEXT: reg_rdata = first_addr;
            RA_CTRL: reg_rdata = {{(DATA_W-1){1'b0}}, busy};
            RA_STAT: reg_rdata = {{(DATA_W-ST_W){1'b0}}, status};
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/xfe_seq.sv
module xfe_seq
    import xfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic [DATA_W-1:0] first_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output acc_op_e           acc_op,
    output logic [DATA_W-1:0] acc_din,
    input  logic [DATA_W-1:0] acc_q,
    output logic              busy,
    output evt_t              evt
);
    localparam int FI_W   = $clog2(DESC_WORDS);
    localparam int SLOT_W = $clog2(MAX_SRC);
    localparam logic [FI_W-1:0] FI_BASE_LAST = FI_W'(DESC_HDR + BASE_SLOTS - 1);
    localparam logic [FI_W-1:0] FI_EXT_LAST  = FI_W'(DESC_WORDS - 1);

    seq_st_e             state_q;
    logic [DATA_W-1:0]   dw_q [DESC_WORDS];
    logic [DATA_W-1:0]   cur_q, off_q;
    logic [FI_W-1:0]     fi_q;
    logic [SLOT_W-1:0]   slot_q;

    logic [DATA_W-1:0]   ctrl, src_sel, off_nx;
    logic [CMD_W-1:0]    cmd;
    logic [FI_W-1:0]     last_fi;
    logic ext, dwe, slot_live, slot_last, is_fill, is_rd, last_word;
    logic fetch_done, wr_go, desc_end, chain_end;

    assign ctrl      = dw_q[W_CTRL];
    assign ext       = ctrl[EXT_BIT];
    assign dwe       = ctrl[DWE_BIT];
    assign cmd       = ctrl[CMD_W*slot_q +: CMD_W];
    assign src_sel   = dw_q[FI_W'(DESC_HDR) + FI_W'(slot_q)];
    assign last_fi   = ext ? FI_EXT_LAST : FI_BASE_LAST;
    assign slot_live = (slot_q < SLOT_W'(BASE_SLOTS)) || ext;
    assign slot_last = (slot_q == SLOT_W'(MAX_SRC - 1));
    assign is_fill   = (slot_q == '0) && (cmd == CMD_FILL);
    assign is_rd     = ((cmd == CMD_LOAD) || (cmd == CMD_XOR)) && slot_live;
    assign off_nx    = off_q + 32'd4;
    assign last_word = (off_nx >= dw_q[W_BC]);

    assign fetch_done = (state_q == S_FETCH) && mem_ack && !mem_err && (fi_q == last_fi);
    assign wr_go      = (state_q == S_WRITE) && !mem_err && (dwe ? mem_ack : 1'b1);
    assign desc_end   = (fetch_done && (dw_q[W_BC] == '0)) || (wr_go && last_word);
    assign chain_end  = desc_end && (dw_q[W_NEXT] == '0);

    assign busy      = (state_q != S_IDLE);
    assign evt.done  = chain_end && !stop;
    assign evt.ie    = ctrl[IE_BIT];
    assign evt.abort = mem_req && mem_err && !stop;

    always_comb begin
        mem_req   = (state_q == S_FETCH) || (state_q == S_READ) || ((state_q == S_WRITE) && dwe);
        mem_we    = (state_q == S_WRITE);
        mem_wdata = acc_q;
        case (state_q)
            S_FETCH: mem_addr = cur_q + 32'({fi_q, 2'b00});
            S_READ:  mem_addr = src_sel + off_q;
            S_WRITE: mem_addr = dw_q[W_DST] + off_q;
            default: mem_addr = '0;
        endcase
        acc_op  = ACC_HOLD;
        acc_din = mem_rdata;
        if ((state_q == S_SLOT) && is_fill) begin
            acc_op  = ACC_LOAD;
            acc_din = dw_q[DESC_HDR];
        end else if ((state_q == S_READ) && mem_ack && !mem_err) begin
            acc_op = (cmd == CMD_LOAD) ? ACC_LOAD : ACC_XOR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
            off_q   <= '0;
            fi_q    <= '0;
            slot_q  <= '0;
            for (int i = 0; i < DESC_WORDS; i++) dw_q[i] <= '0;
        end else if (stop) begin
            state_q <= S_IDLE;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    cur_q   <= align_desc(first_addr);
                    fi_q    <= '0;
                    state_q <= S_FETCH;
                end
                S_FETCH: if (mem_err) begin
                    state_q <= S_IDLE;
                end else if (mem_ack) begin
                    dw_q[fi_q] <= mem_rdata;
                    if (fi_q == last_fi) begin
                        off_q  <= '0;
                        slot_q <= '0;
                        if (dw_q[W_BC] != '0) begin
                            state_q <= S_SLOT;
                        end else if (dw_q[W_NEXT] == '0) begin
                            state_q <= S_IDLE;
                        end else begin
                            cur_q <= align_desc(dw_q[W_NEXT]);
                            fi_q  <= '0;
                        end
                    end else begin
                        fi_q <= fi_q + FI_W'(1);
                    end
                end
                S_SLOT: begin
                    if (is_fill)        state_q <= S_WRITE;
                    else if (is_rd)     state_q <= S_READ;
                    else if (slot_last) state_q <= S_WRITE;
                    else                slot_q  <= slot_q + SLOT_W'(1);
                end
                S_READ: if (mem_err) begin
                    state_q <= S_IDLE;
                end else if (mem_ack) begin
                    if (slot_last) begin
                        state_q <= S_WRITE;
                    end else begin
                        slot_q  <= slot_q + SLOT_W'(1);
                        state_q <= S_SLOT;
                    end
                end
                S_WRITE: if (dwe && mem_err) begin
                    state_q <= S_IDLE;
                end else if (wr_go) begin
                    off_q  <= off_nx;
                    slot_q <= '0;
                    if (!last_word) begin
                        state_q <= S_SLOT;
                    end else if (dw_q[W_NEXT] == '0) begin
                        state_q <= S_IDLE;
                    end else begin
                        cur_q   <= align_desc(dw_q[W_NEXT]);
                        fi_q    <= '0;
                        state_q <= S_FETCH;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xfe_top.sv
module xfe_top
    import xfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              irq
);
    logic              start_w, stop_w, busy_w;
    logic [DATA_W-1:0] first_w, acc_w, acc_din_w;
    logic [ST_W-1:0]   status_w;
    acc_op_e           acc_op_w;
    evt_t              evt_w;

    xfe_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy_w), .evt(evt_w),
        .reg_rdata(reg_rdata), .first_addr(first_w), .start(start_w),
        .stop(stop_w), .status(status_w), .irq(irq)
    );

    xfe_seq u_seq (
        .clk(clk), .rst(rst), .start(start_w), .stop(stop_w),
        .first_addr(first_w), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .acc_op(acc_op_w),
        .acc_din(acc_din_w), .acc_q(acc_w), .busy(busy_w), .evt(evt_w)
    );

    xfe_acc u_acc (
        .clk(clk), .rst(rst), .op(acc_op_w), .din(acc_din_w), .acc(acc_w)
    );
endmodule

// File: rtl/xfe_chk.sv
module xfe_chk
    import xfe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [RA_W-1:0]   reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              mem_req,
    input logic [DATA_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              mem_err,
    input logic              irq,
    input logic [ST_W-1:0]   status
);
    logic stop_req;
    assign stop_req = reg_wr && (reg_addr == RA_CTRL) && !reg_wdata[0];

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (status == '0 && !irq && !mem_req));

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        !status[ST_ACT] |-> !mem_req);

    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !mem_err && !stop_req) |=> (mem_req && $stable(mem_addr)));

    p_abort_flag_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_err && !stop_req) |=> (status[ST_MA] && !status[ST_ACT]));

    p_stop_halts_r12: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> (!status[ST_ACT] && !mem_req));

    p_irq_at_end_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !status[ST_ACT]);
endmodule

bind xfe_top xfe_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq), .status(status_w)
);

// File: tb/xfe_top_test.sv
`timescale 1ns/1ps
module xfe_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, irq;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0, mem_err = 1'b0;

    logic [31:0] mem [0:3071];
    logic [31:0] exp_a [$];
    logic [31:0] exp_d [$];
    logic [31:0] sa [8];
    bit          track = 1'b1;
    bit          finished = 1'b0;
    int          n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    xfe_top uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem[a[13:2]];
    endfunction

    // memory model: one-cycle response, error above 0x3000; each write compared as accepted
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
            if (mem_req && !mem_ack && !mem_err) begin
                if (mem_addr >= 32'h3000) begin
                    mem_err <= 1'b1;
                end else begin
                    mem_ack   <= 1'b1;
                    mem_rdata <= mem[mem_addr[13:2]];
                    if (mem_we) begin
                        mem[mem_addr[13:2]] <= mem_wdata;
                        if (track) begin
                            if (exp_a.size() == 0) begin
                                check(1'b0, "R8 unexpected write", mem_addr, 32'h0);
                            end else begin
                                check(mem_addr == exp_a[0], "R8 write address", mem_addr, exp_a[0]);
                                check(mem_wdata == exp_d[0], "R4 write data", mem_wdata, exp_d[0]);
                                void'(exp_a.pop_front());
                                void'(exp_d.pop_front());
                            end
                        end
                    end
                end
            end
        end
    end

    function automatic logic [31:0] mk_ctrl(input int n, input bit fill, input bit dwe, input bit ie);
        logic [31:0] c = '0;
        if (fill) c[2:0] = 3'd3;
        else begin
            c[2:0] = 3'd1;
            for (int s = 1; s < n; s++) c[3*s +: 3] = 3'd2;
        end
        c[24] = (n > 4);
        c[25] = dwe;
        c[26] = ie;
        return c;
    endfunction

    task automatic put_desc(input logic [31:0] base, input logic [31:0] nxt, input logic [31:0] ctl,
                            input logic [31:0] bc, input logic [31:0] dst);
        mem[base[13:2]]     = nxt;
        mem[base[13:2] + 1] = ctl;
        mem[base[13:2] + 2] = bc;
        mem[base[13:2] + 3] = dst;
        for (int s = 0; s < 8; s++) mem[base[13:2] + 4 + s] = sa[s];
    endtask

    // expected destination writes, interpreted from the descriptor rules
    task automatic push_chain(input logic [31:0] first);
        logic [31:0] d = {first[31:5], 5'b0};
        for (int g = 0; g < 16; g++) begin
            logic [31:0] ctl = rd(d + 4);
            logic [31:0] bc  = rd(d + 8);
            logic [31:0] dst = rd(d + 12);
            for (int w = 0; w < int'(bc / 4); w++) begin
                logic [31:0] v = '0;
                if (ctl[2:0] == 3'd3) v = rd(d + 16);
                else begin
                    for (int s = 0; s < 8; s++) begin
                        if (s >= 4 && !ctl[24]) continue;
                        if (ctl[3*s +: 3] == 3'd1) v = rd(rd(d + 16 + 4*s) + 4*w);
                        else if (ctl[3*s +: 3] == 3'd2) v = v ^ rd(rd(d + 16 + 4*s) + 4*w);
                    end
                end
                if (ctl[25]) begin
                    exp_a.push_back(dst + 4*w);
                    exp_d.push_back(v);
                end
            end
            if (rd(d) == 0) break;
            d = {rd(d) >> 5, 5'b0};
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic get_stat(output logic [31:0] v);
        reg_addr = 2'd2;
        #1;
        v = reg_rdata;
    endtask

    task automatic run_chain(input logic [31:0] first);
        logic [31:0] st;
        reg_write(2'd0, first);
        reg_write(2'd1, 32'd1);
        for (int t = 0; t < 5000; t++) begin
            get_stat(st);
            if (!st[0]) break;
            @(negedge clk);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        summary();
    end

    initial begin
        logic [31:0] st, v;
        for (int i = 0; i < 3072; i++) begin
            if (i >= 1024 && i < 2048) mem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0F0F;
            else if (i >= 2048)        mem[i] = 32'hDEAD0000 | i;
            else                       mem[i] = '0;
        end
        repeat (4) @(negedge clk);
        // R1 reset state
        get_stat(st);
        check(st == 32'h0, "R1 status in reset", st, 32'h0);
        check(!irq && !mem_req, "R1 irq/req in reset", {30'b0, irq, mem_req}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        get_stat(st);
        check(st == 32'h0, "R1 status after reset", st, 32'h0);

        // R2/R3 single copy, first pointer with low bits set
        for (int s = 0; s < 8; s++) sa[s] = 32'h1000 + 32'h100 * s;
        put_desc(32'h000, 32'h0, mk_ctrl(1, 0, 1, 1), 32'd32, 32'h2000);
        push_chain(32'h000);
        run_chain(32'h007);
        check(exp_a.size() == 0, "R2 all copy writes seen", exp_a.size(), 32'h0);
        check(rd(32'h201C) == rd(32'h101C), "R3 copied word", rd(32'h201C), rd(32'h101C));
        get_stat(st);
        check(st == 32'h6, "R9 status after IE chain", st, 32'h6);
        check(irq == 1'b1, "R9 irq high", {31'b0, irq}, 32'h1);
        reg_write(2'd2, 32'h0);
        get_stat(st);
        check(st == 32'h6, "R10 zero write keeps flags", st, 32'h6);
        reg_write(2'd2, 32'h2);
        get_stat(st);
        check(st == 32'h4, "R10 clear only end-of-chain", st, 32'h4);
        check(irq == 1'b0, "R10 irq cleared", {31'b0, irq}, 32'h0);
        reg_write(2'd2, 32'h4);

        // R4/R8 chain of three: 2, 5 and 8 sources
        put_desc(32'h040, 32'h080, mk_ctrl(2, 0, 1, 0), 32'd16, 32'h2100);
        put_desc(32'h080, 32'h0C0, mk_ctrl(5, 0, 1, 1), 32'd24, 32'h2200);
        put_desc(32'h0C0, 32'h000, mk_ctrl(8, 0, 1, 1), 32'd40, 32'h2300);
        push_chain(32'h040);
        run_chain(32'h040);
        check(exp_a.size() == 0, "R8 all chain writes seen", exp_a.size(), 32'h0);
        v = '0;
        for (int s = 0; s < 8; s++) v = v ^ rd(32'h1000 + 32'h100 * s + 32'h24);
        check(rd(32'h2324) == v, "R4 eight-source XOR", rd(32'h2324), v);
        get_stat(st);
        check(st == 32'h6, "R9 status after chain", st, 32'h6);
        reg_write(2'd2, 32'hE);

        // R5 slots 5..8 ignored without the extended enable
        put_desc(32'h100, 32'h0, mk_ctrl(6, 0, 1, 0) & ~(32'h1 << 24), 32'd16, 32'h2400);
        push_chain(32'h100);
        run_chain(32'h100);
        check(exp_a.size() == 0, "R5 writes seen", exp_a.size(), 32'h0);
        v = rd(32'h1008) ^ rd(32'h1108) ^ rd(32'h1208) ^ rd(32'h1308);
        check(rd(32'h2408) == v, "R5 only slots 1-4 combined", rd(32'h2408), v);
        reg_write(2'd2, 32'hE);

        // R6/R7 fill, zero fill, then a descriptor with writes disabled, no IE at end
        sa[0] = 32'hA5A5A5A5;
        put_desc(32'h140, 32'h180, mk_ctrl(1, 1, 1, 1), 32'd20, 32'h2500);
        sa[0] = 32'h0;
        put_desc(32'h180, 32'h1C0, mk_ctrl(1, 1, 1, 0), 32'd12, 32'h2600);
        sa[0] = 32'h1000;
        put_desc(32'h1C0, 32'h000, mk_ctrl(1, 0, 0, 0), 32'd16, 32'h2700);
        push_chain(32'h140);
        run_chain(32'h140);
        check(exp_a.size() == 0, "R6 fill writes seen", exp_a.size(), 32'h0);
        check(rd(32'h2510) == 32'hA5A5A5A5, "R6 pattern fill", rd(32'h2510), 32'hA5A5A5A5);
        check(rd(32'h2608) == 32'h0, "R6 zero fill", rd(32'h2608), 32'h0);
        check(rd(32'h2700) == (32'hDEAD0000 | 32'd2496), "R7 no write when disabled", rd(32'h2700), 32'hDEAD0000 | 32'd2496);
        get_stat(st);
        check(st == 32'h4, "R9 end-of-transfer only", st, 32'h4);
        check(irq == 1'b0, "R9 irq low without IE", {31'b0, irq}, 32'h0);
        reg_write(2'd2, 32'hE);

        // R11 error response on the source read
        sa[0] = 32'h3000;
        put_desc(32'h200, 32'h0, mk_ctrl(1, 0, 1, 1), 32'd16, 32'h2800);
        run_chain(32'h200);
        get_stat(st);
        check(st == 32'h8, "R11 master abort only", st, 32'h8);
        check(rd(32'h2800) == (32'hDEAD0000 | 32'd2560), "R11 no write after abort", rd(32'h2800), 32'hDEAD0000 | 32'd2560);
        reg_write(2'd2, 32'h8);

        // R12/R13 stop while running
        track = 1'b0;
        sa[0] = 32'h1000;
        put_desc(32'h240, 32'h0, mk_ctrl(1, 0, 1, 1), 32'd64, 32'h2900);
        reg_write(2'd0, 32'h240);
        reg_write(2'd1, 32'd1);
        repeat (20) @(negedge clk);
        get_stat(st);
        check(st[0] == 1'b1, "R13 active while running", st, 32'h1);
        reg_write(2'd1, 32'd0);
        get_stat(st);
        check(st[0] == 1'b0 && !mem_req, "R12 stopped", {st[30:0], mem_req}, 32'h0);
        repeat (10) @(negedge clk);
        get_stat(st);
        check(st == 32'h0 && !mem_req, "R12 quiet, no flags after stop", st, 32'h0);
        @(negedge clk);
        track = 1'b1;

        // R10 completion set and clearing write on the same edge
        put_desc(32'h280, 32'h0, mk_ctrl(1, 0, 1, 1), 32'd8, 32'h2A00);
        push_chain(32'h280);
        reg_write(2'd0, 32'h280);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'd1;
        @(negedge clk);
        reg_addr = 2'd2; reg_wdata = 32'h2;
        #1;
        for (int t = 0; t < 2000 && reg_rdata[0]; t++) begin
            @(negedge clk);
            #1;
        end
        reg_wr = 1'b0;
        get_stat(st);
        check(st == 32'h6, "R10 set wins over clear", st, 32'h6);
        check(exp_a.size() == 0, "R8 short chain writes seen", exp_a.size(), 32'h0);

        summary();
    end
endmodule